// File: doc/BRIEF.md
# Iterative Fibonacci Sequence Unit

This block computes the n-th term of the Fibonacci sequence by running an add-and-shift recurrence, one step per clock. A caller pulses `start_i` with an unsigned term index on `n_i`. The unit seeds two history registers with 0 and 1, presets its result register to their sum, and advances the recurrence once per cycle while its down-counter is above one. When the loop ends it pulses `done_o` for one cycle and keeps the result on `fib_o` until the next accepted start.

The sequence follows F(1) = F(2) = 1 and F(k) = F(k-1) + F(k-2). Indices 0 and 1 take no steps and return 1. Results are 32 bits wide and wrap modulo 2^32. A start that arrives while the unit is working is ignored, and a start in the cycle that `done_o` is high is accepted, so requests can run back to back.

Top module: `fib_iter`

## Requirements
- R1: After synchronous reset `busy_o` and `done_o` are 0 and `fib_o` is 0.
- R2: An accepted start with `n_i` of 0 or 1 takes no step: `busy_o` stays 0, and in the cycle after the start edge `done_o` is 1 and `fib_o` is 1.
- R3: An accepted start with `n_i` of 2 or more raises `busy_o` for exactly `n_i`-1 cycles starting after the start edge, and `done_o` rises in the cycle that `busy_o` falls.
- R4: When `done_o` is 1, `fib_o` equals F(`n_i`) with F(1) = F(2) = 1 and F(k) = F(k-1) + F(k-2); F(10) = 55 and F(47) = 2971215073.
- R5: The result wraps modulo 2^32; F(48) is returned as 512559680.
- R6: `done_o` is a single-cycle pulse per request and is never high together with `busy_o`.
- R7: After `done_o`, `fib_o` holds its value on every cycle until the next accepted start.
- R8: A start while `busy_o` is 1 is ignored: the running request completes in the same cycle and with the same value as without it, and no extra `done_o` pulse follows.
- R9: A start in the cycle where `done_o` is 1 and `busy_o` is 0 is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse, accepted only while not busy |
| n_i | input | 16 | Unsigned term index, sampled with an accepted start |
| busy_o | output | 1 | High while recurrence steps are pending |
| done_o | output | 1 | One-cycle pulse when the result is final |
| fib_o | output | 32 | Result value, wraps modulo 2^32 |

## Verification
On every cycle the assertions check that the counter stays above one while busy and always decrements so a mid-run start cannot disturb it, that done and busy never overlap, that a load seeds the histories with 0 and 1 and a result of 1, that the result mirrors the second history after each update, and that the result is held when nothing is loaded or stepped. Only the bench scenarios can show that the value at done is the right term, that the busy window has exactly n-1 cycles, that wrapping gives the expected low 32 bits for large indices, and that back-to-back and intruding starts produce the right sequence of completions.

// File: rtl/fib_pkg.sv
package fib_pkg;

    // Command issued by the sequencer to the recurrence datapath.
    typedef struct packed {
        logic load;   // seed histories and result
        logic step;   // advance the recurrence by one term
    } fib_cmd_t;

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
#(
    parameter int N_W = 16
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           start_i,
    input  logic [N_W-1:0] n_i,
    output fib_cmd_t       cmd_o,
    output logic           busy_o,
    output logic           done_o
);

    localparam logic [N_W-1:0] CNT_ONE = N_W'(1);
    localparam logic [N_W-1:0] CNT_TWO = N_W'(2);

    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic           busy;
        logic           done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept;
    logic  last_step;

    always_comb begin
        accept    = start_i && !ctl_q.busy;
        last_step = ctl_q.busy && (ctl_q.cnt == CNT_TWO);
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) begin
            ctl_d.cnt  = n_i;
            ctl_d.busy = (n_i > CNT_ONE);
            ctl_d.done = (n_i <= CNT_ONE);
        end else if (ctl_q.busy) begin
            ctl_d.cnt  = ctl_q.cnt - CNT_ONE;
            ctl_d.busy = !last_step;
            ctl_d.done = last_step;
        end
        cmd_o.load = accept;
        cmd_o.step = ctl_q.busy;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;

    // R3: a running loop always has more than one term left
    a_r3_cnt_above_one: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_q.busy |-> (ctl_q.cnt > CNT_ONE));

    // R8: while busy the counter only counts down, whatever start does
    a_r8_busy_ignores_start: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_q.busy |=> (ctl_q.cnt == $past(ctl_q.cnt) - CNT_ONE));

    // R6: done and busy never overlap
    a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_q.done |-> !ctl_q.busy);

    // R6: without a new request, done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_q.done && !start_i) |=> !ctl_q.done);

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath
    import fib_pkg::*;
#(
    parameter int R_W = 32
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  fib_cmd_t       cmd_i,
    output logic [R_W-1:0] res_o
);

    localparam logic [R_W-1:0] SEED_LO = '0;
    localparam logic [R_W-1:0] SEED_HI = R_W'(1);

    typedef struct packed {
        logic [R_W-1:0] hist_a;   // older term
        logic [R_W-1:0] hist_b;   // newer term
        logic [R_W-1:0] res;
    } dp_t;

    dp_t            dp_d, dp_q;
    logic [R_W-1:0] sum;

    always_comb begin
        sum  = dp_q.hist_a + dp_q.hist_b;   // wraps modulo 2^R_W
        dp_d = dp_q;
        if (cmd_i.load) begin
            dp_d.hist_a = SEED_LO;
            dp_d.hist_b = SEED_HI;
            dp_d.res    = SEED_LO + SEED_HI;
        end else if (cmd_i.step) begin
            dp_d.res    = sum;
            dp_d.hist_a = dp_q.hist_b;
            dp_d.hist_b = sum;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign res_o = dp_q.res;

    // R2: a load seeds histories 0 and 1 and a result of 1
    a_r2_load_seed: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i.load |=> (dp_q.hist_a == SEED_LO && dp_q.hist_b == SEED_HI
                        && dp_q.res == SEED_HI));

    // R4: after any update the result equals the newer history term
    a_r4_res_tracks_hist: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i.load || cmd_i.step) |=> (dp_q.res == dp_q.hist_b));

    // R7: no command, no change to the result
    a_r7_hold_result: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cmd_i.load && !cmd_i.step) |=> $stable(dp_q.res));

endmodule

// File: rtl/fib_iter.sv
module fib_iter
    import fib_pkg::*;
#(
    parameter int N_W = 16,
    parameter int R_W = 32
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           start_i,
    input  logic [N_W-1:0] n_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [R_W-1:0] fib_o
);

    fib_cmd_t cmd;

    fib_ctrl #(
        .N_W (N_W)
    ) i_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .n_i     (n_i),
        .cmd_o   (cmd),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    fib_datapath #(
        .R_W (R_W)
    ) i_dp (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cmd_i (cmd),
        .res_o (fib_o)
    );

    // R2: indices 0 and 1 finish at once with value 1
    a_r2_small_index: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o && (n_i <= N_W'(1))) |=> (done_o && !busy_o && fib_o == R_W'(1)));

    // R9: an idle unit accepts a start even while done is high
    a_r9_accept_on_done: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && done_o && (n_i > N_W'(1))) |=> busy_o);

endmodule

// File: tb/test_fib_iter.sv
`timescale 1ns/1ps
module test_fib_iter;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] n_in;
    logic        busy;
    logic        done;
    logic [31:0] fib;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // scoreboard queues, one entry per expected completion
    int          q_start[$];
    int          q_done[$];
    logic [31:0] q_val[$];
    int          q_n[$];
    string       q_tag[$];

    logic [31:0] last_res = '0;
    bit          have_last = 1'b0;

    always #2.5 clk = ~clk;

    fib_iter i_fib_iter (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .n_i     (n_in),
        .busy_o  (busy),
        .done_o  (done),
        .fib_o   (fib)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference from F(1)=F(2)=1, F(k)=F(k-1)+F(k-2), with F(0) returned as 1.
    function automatic logic [31:0] fib_ref(input int n);
        logic [31:0] prev = 32'd1;
        logic [31:0] cur  = 32'd1;
        logic [31:0] nxt;
        for (int k = 3; k <= n; k++) begin
            nxt  = prev + cur;
            prev = cur;
            cur  = nxt;
        end
        return cur;
    endfunction

    // Called at a negedge; returns at the negedge of the done cycle.
    task automatic run(input int n, input logic [31:0] exp, input string tag);
        int lat;
        lat   = (n <= 1) ? 0 : n - 1;
        start = 1'b1;
        n_in  = 16'(n);
        q_n.push_back(n);
        q_val.push_back(exp);
        q_start.push_back(cyc + 1);
        q_done.push_back(cyc + 1 + lat);
        q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        n_in  = 16'hBEEF;
        while (q_n.size() != 0) @(negedge clk);
    endtask

    // R8: same as run, but a start with another index intrudes while busy
    task automatic run_intrude(input int n, input int after, input int n_bad);
        int lat;
        lat   = n - 1;
        start = 1'b1;
        n_in  = 16'(n);
        q_n.push_back(n);
        q_val.push_back(fib_ref(n));
        q_start.push_back(cyc + 1);
        q_done.push_back(cyc + 1 + lat);
        q_tag.push_back("R8");
        @(negedge clk);
        start = 1'b0;
        repeat (after) @(negedge clk);
        start = 1'b1;
        n_in  = 16'(n_bad);
        @(negedge clk);
        start = 1'b0;
        while (q_n.size() != 0) @(negedge clk);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Monitor: samples 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (!rst) begin
                if (q_n.size() != 0) begin
                    if (cyc < q_done[0]) begin
                        check(busy === 1'b1 && done === 1'b0, "R3 busy window",
                              {30'd0, busy, done}, 32'd2);
                    end else if (cyc == q_done[0]) begin
                        check(done === 1'b1 && busy === 1'b0, "R6 done pulse",
                              {30'd0, busy, done}, 32'd1);
                        check(fib === q_val[0], q_tag[0], fib, q_val[0]);
                        last_res  = fib;
                        have_last = 1'b1;
                        void'(q_n.pop_front());
                        void'(q_val.pop_front());
                        void'(q_start.pop_front());
                        void'(q_done.pop_front());
                        void'(q_tag.pop_front());
                    end
                end else begin
                    check(done === 1'b0 && busy === 1'b0, "R6 idle no pulse",
                          {30'd0, busy, done}, 32'd0);
                    if (have_last) check(fib === last_res, "R7 hold", fib, last_res);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        n_in  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
        check(done === 1'b0, "R1 done", {31'd0, done}, 32'd0);
        check(fib === 32'd0, "R1 result", fib, 32'd0);

        // R2: indices with no steps
        run(0, 32'd1, "R2 n=0");
        idle(2);
        run(1, 32'd1, "R2 n=1");
        idle(3);

        // R4: known terms and a sweep
        run(2, 32'd1, "R4 n=2");
        run(3, 32'd2, "R4 n=3");
        run(10, 32'd55, "R4 n=10");
        idle(4);
        run(47, 32'd2971215073, "R4 n=47");
        for (int n = 4; n <= 20; n++) run(n, fib_ref(n), "R4 sweep");

        // R5: wrap past 32 bits
        run(48, 32'd512559680, "R5 n=48");
        run(300, fib_ref(300), "R5 n=300");
        idle(5);

        // R9: back to back, including small index straight after a long run
        run(25, fib_ref(25), "R9 b2b");
        run(1, 32'd1, "R9 b2b small");
        run(0, 32'd1, "R9 b2b zero");
        run(6, 32'd8, "R9 b2b after small");

        // R8: intruding starts while busy
        run_intrude(12, 3, 1);
        run_intrude(30, 10, 100);
        idle(6);
        run_intrude(5, 0, 40);
        idle(6);

        // R7: long idle hold
        idle(20);
        check(fib === 32'd5, "R7 final hold", fib, 32'd5);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule